// File: doc/BRIEF.md
# Watchdog Timer with NMI Stage

The block is a watchdog built around a 9-bit two's-complement down-counter. Each cycle in which the tick strobe (from an external prescaler, nominally one pulse every 10.24 ms) is high and counting is not paused, the counter drops by one. The counter runs through zero into negative values. Software keeps the system alive by writing a fresh count through a 16-bit register port. That write is accepted only if its top seven data bits are zero, so that runaway code storing arbitrary data is unlikely to feed the dog.

In the default mode the block emits a one-cycle non-maskable interrupt pulse when a tick brings the counter to zero. It requests a system reset when the counter reaches -16 (0x1F0). Software may set a one-way lock bit. While the lock bit is set, any zero or negative count requests a reset at once, and the pause requests are ignored. A debug-halt input pauses counting in either mode. A watchdog reset reloads the count to 0x0FF and clears the lock bit. The reset request lasts one cycle, because the reload removes its cause.

Top module: `wdt_nmi`

## Requirements
- R1: After rst_n deasserts, a read at address 0 returns 0x00FF, a read at address 2 returns 0x0000, and nmi and wd_rst are low.
- R2: Each cycle with tick high, dbg_halt low and no active pause, the counter decrements by one and wraps from 0x000 to 0x1FF. A read at address 0 returns {7'b0, counter}.
- R3: A write to address 0 loads wdata[8:0] into the counter only when wdata[15:9] is zero. Any other write to address 0 leaves the counter unchanged.
- R4: An accepted counter write in the same cycle as a tick loads the written value, and the decrement is dropped.
- R5: With the lock bit at 0, nmi is high for exactly one cycle: the cycle after the tick that moves the counter from 1 to 0. It is not raised again while the counter stays at 0, and it is not raised by a write of 0.
- R6: With the lock bit at 0, wd_rst is high while the counter equals 0x1F0, and not at other negative values above it.
- R7: With the lock bit at 1, wd_rst is high while the counter is 0 or negative (bit 8 set), and nmi stays low.
- R8: Writing 1 to bit 0 at address 2 sets the lock bit, and writing 0 does not clear it. The lock bit reads back in bit 0 of address 2. When wd_rst is high, the next clock edge loads 0x0FF into the counter and clears the lock bit.
- R9: With the lock bit at 0, a freeze_set pulse pauses counting until a freeze_clr pulse resumes it. If both pulse in the same cycle, the resume wins.
- R10: With the lock bit at 1, freeze_set has no effect and ticks keep decrementing the counter.
- R11: While dbg_halt is high, ticks do not change the counter, whatever the lock bit.
- R12: Reads at addresses other than 0 and 2 return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset (power-on or software reset) |
| tick | input | 1 | Time-base strobe, one cycle per count period |
| addr | input | 2 | Register byte offset |
| we | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for addr (combinational) |
| freeze_set | input | 1 | Request to pause counting |
| freeze_clr | input | 1 | Request to resume counting |
| dbg_halt | input | 1 | Processor halted in debug; pauses counting |
| nmi | output | 1 | Non-maskable interrupt pulse |
| wd_rst | output | 1 | System reset request |

## Verification
The counting path is tried with counts that start positive and then cross zero, so the bench can confirm that the sign bit and the wrap to 0x1FF behave correctly. Counts placed just above -16 show that the reset in the unlocked mode fires only at 0x1F0, while a count of zero and a count of 0x1FF in the locked mode show that the reset fires on any non-positive value. Writes with a high bit set are compared with filtered writes, and writes that coincide with a tick are compared with plain ticks, so that the write guard and the reload priority can be told apart. Ticks given under freeze, under debug halt and under lock show which source of pause applies in each mode.

// File: rtl/wdt_nmi.sv
module wdt_nmi #(
  parameter logic [8:0] RELOAD_VAL = 9'h0FF,
  parameter logic [8:0] LAST_VAL   = 9'h1F0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        tick,
  input  logic [1:0]  addr,
  input  logic        we,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  input  logic        freeze_set,
  input  logic        freeze_clr,
  input  logic        dbg_halt,
  output logic        nmi,
  output logic        wd_rst
);
  logic [8:0] cnt;
  logic       lock, frz;

  wire cnt_wr  = we && addr == 2'd0 && wdata[15:9] == 7'd0;
  wire lock_wr = we && addr == 2'd2 && wdata[0];
  wire run     = tick && !dbg_halt && !(frz && !lock);

  assign wd_rst = lock ? (cnt == 9'd0 || cnt[8]) : (cnt == LAST_VAL);

  always_comb begin
    case (addr)
      2'd0:    rdata = {7'd0, cnt};
      2'd2:    rdata = {15'd0, lock};
      default: rdata = 16'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= RELOAD_VAL;
      lock <= 1'b0;
      frz  <= 1'b0;
      nmi  <= 1'b0;
    end else begin
      nmi <= 1'b0;
      if (wd_rst) begin
        cnt  <= RELOAD_VAL;
        lock <= 1'b0;
        frz  <= 1'b0;
      end else begin
        if (lock_wr) lock <= 1'b1;
        if (freeze_clr)                frz <= 1'b0;
        else if (freeze_set && !lock)  frz <= 1'b1;
        if (cnt_wr) cnt <= wdata[8:0];
        else if (run) begin
          cnt <= cnt - 9'd1;
          nmi <= !lock && cnt == 9'd1;
        end
      end
    end
  end
endmodule

module wdt_nmi_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        tick,
  input logic [1:0]  addr,
  input logic        we,
  input logic [15:0] wdata,
  input logic        dbg_halt,
  input logic        nmi,
  input logic        wd_rst,
  input logic [8:0]  cnt,
  input logic        lock
);
  wire good_wr = we && addr == 2'd0 && wdata[15:9] == 7'd0;

  // R3
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    good_wr && !wd_rst |=> cnt == $past(wdata[8:0]));
  // R3
  filter_chk: assert property (@(posedge clk) disable iff (!rst_n)
    we && addr == 2'd0 && wdata[15:9] != 7'd0 && !tick && !wd_rst |=> $stable(cnt));
  // R5
  nmi_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |=> !nmi);
  // R5
  nmi_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmi |-> cnt == 9'd0 && !lock);
  // R8
  rst_reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wd_rst |=> cnt == 9'h0FF && !lock);
  // R8
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    lock && !wd_rst |=> lock);
  // R11
  halt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_halt && !good_wr && !wd_rst |=> $stable(cnt));
endmodule

bind wdt_nmi wdt_nmi_chk chk_i (
  .clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .we(we), .wdata(wdata),
  .dbg_halt(dbg_halt), .nmi(nmi), .wd_rst(wd_rst), .cnt(cnt), .lock(lock)
);

// File: tb/wdt_nmi_tb_top.sv
module wdt_nmi_tb_top;
  logic clk = 0, rst_n = 0, tick = 0, we = 0;
  logic freeze_set = 0, freeze_clr = 0, dbg_halt = 0;
  logic [1:0] addr = 0;
  logic [15:0] wdata = 0, rdata;
  logic nmi, wd_rst;
  int tests = 0, fails = 0;

  always #2 clk = ~clk;

  wdt_nmi dut_i (.clk(clk), .rst_n(rst_n), .tick(tick), .addr(addr), .we(we),
    .wdata(wdata), .rdata(rdata), .freeze_set(freeze_set), .freeze_clr(freeze_clr),
    .dbg_halt(dbg_halt), .nmi(nmi), .wd_rst(wd_rst));

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(logic [1:0] a, output logic [15:0] d);
    addr = a; #0.5; d = rdata;
  endtask

  task automatic chk_cnt(string req, logic [8:0] exp);
    logic [15:0] d;
    rd(2'd0, d); check(req, d, {7'd0, exp});
  endtask

  task automatic wr(logic [1:0] a, logic [15:0] d, bit with_tick = 0);
    @(negedge clk); addr = a; wdata = d; we = 1; tick = with_tick;
    @(negedge clk); we = 0; tick = 0;
  endtask

  task automatic do_tick();
    @(negedge clk); tick = 1;
    @(negedge clk); tick = 0;
  endtask

  task automatic pulse_frz(bit s, bit c);
    @(negedge clk); freeze_set = s; freeze_clr = c;
    @(negedge clk); freeze_set = 0; freeze_clr = 0;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(2'd0, d); check("R1 cnt", d, 16'h00FF);
    rd(2'd2, d); check("R1 ctrl", d, 16'h0000);
    check("R1 nmi", nmi, 0); check("R1 wd_rst", wd_rst, 0);
    rd(2'd1, d); check("R12 addr1", d, 16'h0000);
    rd(2'd3, d); check("R12 addr3", d, 16'h0000);
  endtask

  task automatic t_count();
    wr(2'd0, 16'h0002); chk_cnt("R3 load", 9'h002);
    check("R5 no nmi on write", nmi, 0);
    do_tick(); chk_cnt("R2 dec", 9'h001);
    do_tick(); chk_cnt("R2 zero", 9'h000); check("R5 nmi", nmi, 1);
    @(negedge clk); check("R5 nmi one cycle", nmi, 0);
    do_tick(); chk_cnt("R2 wrap", 9'h1FF); check("R5 no nmi", nmi, 0);
    wr(2'd0, 16'h0000); check("R5 write0 no nmi", nmi, 0);
  endtask

  task automatic t_filter();
    wr(2'd0, 16'h0030); chk_cnt("R3 ok", 9'h030);
    wr(2'd0, 16'h0250); chk_cnt("R3 bit9", 9'h030);
    wr(2'd0, 16'h8011); chk_cnt("R3 bit15", 9'h030);
  endtask

  task automatic t_prio();
    wr(2'd0, 16'h0040); wr(2'd0, 16'h0010, 1);
    chk_cnt("R4 reload over tick", 9'h010);
  endtask

  task automatic t_nmi_freeze();
    wr(2'd0, 16'h0001);
    do_tick(); chk_cnt("R5 at zero", 9'h000); check("R5 nmi", nmi, 1);
    pulse_frz(1, 0); check("R5 nmi gone", nmi, 0);
    for (int i = 0; i < 3; i++) begin
      do_tick(); chk_cnt("R9 frozen", 9'h000); check("R5 not repeated", nmi, 0);
    end
    pulse_frz(0, 1);
    do_tick(); chk_cnt("R9 resumed", 9'h1FF);
    pulse_frz(1, 1);
    do_tick(); chk_cnt("R9 clr wins", 9'h1FE);
  endtask

  task automatic t_neg_reset();
    wr(2'd0, 16'h01F2);
    do_tick(); chk_cnt("R6 -15", 9'h1F1); check("R6 no rst", wd_rst, 0);
    do_tick(); chk_cnt("R6 -16", 9'h1F0); check("R6 rst", wd_rst, 1);
    @(negedge clk); chk_cnt("R8 reload", 9'h0FF); check("R6 rst one cycle", wd_rst, 0);
  endtask

  task automatic t_lock();
    logic [15:0] d;
    wr(2'd2, 16'h0001); rd(2'd2, d); check("R8 lock set", d, 16'h0001);
    wr(2'd2, 16'h0000); rd(2'd2, d); check("R8 lock sticky", d, 16'h0001);
    wr(2'd0, 16'h0003);
    pulse_frz(1, 0);
    do_tick(); chk_cnt("R10 freeze ignored", 9'h002);
    do_tick(); chk_cnt("R10 still counting", 9'h001); check("R7 no rst yet", wd_rst, 0);
    do_tick(); chk_cnt("R7 zero", 9'h000);
    check("R7 rst", wd_rst, 1); check("R7 no nmi", nmi, 0);
    @(negedge clk); chk_cnt("R8 reload", 9'h0FF);
    rd(2'd2, d); check("R8 lock cleared", d, 16'h0000);
    do_tick(); chk_cnt("R9 freeze cleared by rst", 9'h0FE);
    wr(2'd2, 16'h0001); wr(2'd0, 16'h01FF);
    check("R7 negative rst", wd_rst, 1);
    @(negedge clk); chk_cnt("R8 reload2", 9'h0FF);
  endtask

  task automatic t_dbg();
    wr(2'd0, 16'h0020);
    @(negedge clk); dbg_halt = 1;
    do_tick(); do_tick(); chk_cnt("R11 halt unlocked", 9'h020);
    wr(2'd2, 16'h0001);
    do_tick(); chk_cnt("R11 halt locked", 9'h020);
    @(negedge clk); dbg_halt = 0;
    do_tick(); chk_cnt("R11 released", 9'h01F);
  endtask

  initial begin
    #1; rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset(); t_count(); t_filter(); t_prio();
    t_nmi_freeze(); t_neg_reset(); t_lock(); t_dbg();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    tests++; fails++;
    $display("FAIL watchdog: run did not finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule